// File: doc/BRIEF.md
# Conflict-Free Bank Address Generator for a Four-Lane FFT

This block produces the memory addresses for a 1024-point FFT whose four radix-8 processing lanes share eight single-port banks of 128 words. A start pulse, taken together with a stage code, launches one pass of a shared 8-bit butterfly counter. Each lane combines that count with its own fixed 2-bit lane number through a bit permutation chosen by the stage. The permutation gives a 10-bit logical address. From that address the block derives a bank number and a word offset inside the bank.

For every lane the block drives a read port (valid, bank, word). It also drives a write port that repeats the same bank and word after the lane's pipeline latency. The issue schedule is arranged so that no bank is ever asked for more than one access in a cycle, counting reads and writes together. The stage 1 pass runs back to back. The stage 2 and stage 3 passes work in groups of 32 counts, with a pause after each group that lets the group's writes finish. In stage 3 the two upper lanes run one cycle behind the two lower ones.

Top module: `conflict_free_agen`

## Requirements
- R1: After reset, `busy_o`, `done_o`, every `rd_vld_o` bit and every `wr_vld_o` bit are low.
- R2: A start pulse seen while idle launches a pass if `stage_i` is 0, 1 or 2 (stage 1, 2 or 3). With `stage_i` equal to 3 the pulse is ignored, so `busy_o` and all valids stay low.
- R3: For count b and lane p (p1p0), the logical address is built as follows, most significant bit first. Stage 1 uses {b[2:0], b[7:3], p}. Stage 2 uses {b[7:5], b[2:0], b[4:3], p}. Stage 3 uses {b[7:5], b[4:3], p1, b[2:0], p0}. The bank is (addr[9:7] + addr[2:0]) mod 8, and the word is addr[6:0].
- R4: In stage 1, count i (0 to 255) is read by every lane in cycle base+i. Here base is the first cycle after the clock edge that sampled the start pulse.
- R5: In stages 2 and 3, count i belongs to group i/32. It is issued at base + (i/32)·(32+G) + (i mod 32), where the gap G is 24 in stage 2 and 23 in stage 3.
- R6: In stage 3, lanes 2 and 3 read a count one cycle after lanes 0 and 1 read it. In stages 1 and 2 all four lanes read in the same cycle.
- R7: Each read is repeated as a write with the same bank and word. The write comes 24 cycles later in stage 1, 24 in stage 2 and 22 in stage 3.
- R8: In every cycle, each of the eight banks sees at most one access over all read and write ports.
- R9: `done_o` is high for exactly one cycle, the cycle of the pass's final write. `busy_o` is low from the next cycle on.
- R10: A start pulse arriving while a pass is running has no effect on that pass's addresses, timing or completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a pass (taken only when idle) |
| stage_i | input | 2 | Stage code: 0, 1 or 2; 3 is rejected |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle pulse in the final write cycle |
| rd_vld_o | output | 4 | Per-lane read strobe |
| rd_bank_o | output | 12 | Per-lane read bank, 3 bits per lane, lane 0 lowest |
| rd_word_o | output | 28 | Per-lane read word, 7 bits per lane, lane 0 lowest |
| wr_vld_o | output | 4 | Per-lane write strobe |
| wr_bank_o | output | 12 | Per-lane write bank, 3 bits per lane |
| wr_word_o | output | 28 | Per-lane write word, 7 bits per lane |

## Verification
The first read of a pass is due one cycle after the edge that samples start. Later reads follow the issue formula of R4 or R5, with one extra cycle for the upper lanes in stage 3. Writes trail their reads by exactly 24, 24 or 22 cycles, and the done pulse lands on the last write. The driver computes each expected read and write as an absolute cycle number together with a bank and a word, and queues it per lane. The monitor samples on the falling edge, pops an item whenever a strobe is seen, and compares the cycle, bank and word, so a strobe that comes early, late or not at all is reported. The per-bank occupancy is recounted from the ports in every active cycle.

// File: rtl/agen_pkg.sv
// Package: shared stage encoding and sequencer states for the bank address generator.
// Assumes the stage codes on the top-level input use the same numbering.
package agen_pkg;

    typedef enum logic [1:0] {
        STG_1   = 2'd0,
        STG_2   = 2'd1,
        STG_3   = 2'd2,
        STG_BAD = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_GAP   = 2'd2,
        SQ_DRAIN = 2'd3
    } seq_state_e;

    // Larger of three latencies, used to size the history line.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/agen_sequencer.sv
// Module: pass sequencer. Steps the shared butterfly counter from 0 to its full
// count, one value per issue cycle. In stages 2 and 3 it inserts a pause after
// every group of 2**GRP_W counts that lasts until that group's writes are done.
// After the final count it waits for the last write and then pulses done.
// Assumes: start is ignored unless idle; stage code 3 is rejected.
module agen_sequencer
    import agen_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int GRP_W = 5,
    parameter int LAT1  = 24,
    parameter int LAT2  = 24,
    parameter int LAT3  = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       stage_i,
    output stage_e           stage_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             iss_vld_o,
    output logic [CNT_W-1:0] iss_cnt_o
);
    localparam int LAT_MAX = max3(LAT1, LAT2, LAT3);
    localparam int SPAN_W  = $clog2(LAT_MAX + 2);

    seq_state_e        state_q;
    stage_e            stage_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SPAN_W-1:0] wait_q;
    logic [SPAN_W-1:0] span;
    logic              last_cnt;
    logic              grp_end;

    // Pause length: write latency plus the upper-lane skew in stage 3.
    always_comb begin
        unique case (stage_q)
            STG_1:   span = SPAN_W'(LAT1);
            STG_2:   span = SPAN_W'(LAT2);
            default: span = SPAN_W'(LAT3 + 1);
        endcase
    end

    // End-of-pass and end-of-group detection on the current count.
    always_comb begin
        last_cnt = (cnt_q == {CNT_W{1'b1}});
        grp_end  = (stage_q != STG_1) && (cnt_q[GRP_W-1:0] == {GRP_W{1'b1}});
    end

    // State, counter and pause timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            stage_q <= STG_1;
            cnt_q   <= '0;
            wait_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_i && (stage_e'(stage_i) != STG_BAD)) begin
                        stage_q <= stage_e'(stage_i);
                        cnt_q   <= '0;
                        state_q <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_cnt) begin
                        state_q <= SQ_DRAIN;
                        wait_q  <= span - 1'b1;
                    end else if (grp_end) begin
                        state_q <= SQ_GAP;
                        wait_q  <= span - 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (wait_q == '0) state_q <= SQ_ISSUE;
                    else              wait_q  <= wait_q - 1'b1;
                end
                default: begin
                    if (wait_q == '0) state_q <= SQ_IDLE;
                    else              wait_q  <= wait_q - 1'b1;
                end
            endcase
        end
    end

    // Status and issue outputs.
    always_comb begin
        stage_o   = stage_q;
        busy_o    = (state_q != SQ_IDLE);
        done_o    = (state_q == SQ_DRAIN) && (wait_q == '0);
        iss_vld_o = (state_q == SQ_ISSUE);
        iss_cnt_o = cnt_q;
    end

endmodule

// File: rtl/agen_history.sv
// Module: issue history line. Tap k gives the issue (valid and count) from k
// cycles ago; tap 0 is the present issue. Lanes pick their read and write
// taps from it. Assumes N >= 2.
module agen_history #(
    parameter int CNT_W = 8,
    parameter int N     = 26
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic [CNT_W-1:0]          in_cnt,
    output logic [N-1:0]              tap_vld,
    output logic [N-1:0][CNT_W-1:0]   tap_cnt
);
    logic [N-1:1]            vld_q;
    logic [N-1:1][CNT_W-1:0] cnt_q;

    // Shift the issue stream one stage per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            cnt_q <= '0;
        end else begin
            vld_q[1] <= in_vld;
            cnt_q[1] <= in_cnt;
            for (int k = 2; k < N; k++) begin
                vld_q[k] <= vld_q[k-1];
                cnt_q[k] <= cnt_q[k-1];
            end
        end
    end

    // Expose the live issue as tap 0 beside the stored ones.
    always_comb begin
        tap_vld[0] = in_vld;
        tap_cnt[0] = in_cnt;
        for (int k = 1; k < N; k++) begin
            tap_vld[k] = vld_q[k];
            tap_cnt[k] = cnt_q[k];
        end
    end

endmodule

// File: rtl/agen_bank_map.sv
// Module: per-stage digit permutation of {count, lane} into a 10-bit logical
// address, then bank = (top three bits + bottom three bits) mod 8 and
// word = low seven bits. Purely combinational. Assumes an 8-bit count and
// 2-bit lane number (1024 points, eight banks of 128 words).
module agen_bank_map
    import agen_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LANE_W = 2,
    parameter int BANK_W = 3,
    parameter int WORD_W = 7
) (
    input  stage_e              stage,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [LANE_W-1:0]   lane,
    output logic [BANK_W-1:0]   bank,
    output logic [WORD_W-1:0]   word
);
    localparam int ADDR_W = CNT_W + LANE_W;

    logic [ADDR_W-1:0] addr;

    // Stage-dependent bit permutation.
    always_comb begin
        unique case (stage)
            STG_1:   addr = {cnt[2:0], cnt[7:3], lane};
            STG_2:   addr = {cnt[7:5], cnt[2:0], cnt[4:3], lane};
            default: addr = {cnt[7:5], cnt[4:3], lane[1], cnt[2:0], lane[0]};
        endcase
    end

    // Modular bank sum and in-bank offset.
    always_comb begin
        bank = addr[ADDR_W-1 -: BANK_W] + addr[BANK_W-1:0];
        word = addr[WORD_W-1:0];
    end

endmodule

// File: rtl/conflict_free_agen.sv
// Module: top of the bank address generator. A sequencer issues butterfly
// counts; a history line delays them; each lane picks a read tap (skewed by
// one cycle for the upper half of the lanes in stage 3) and a write tap
// (read tap plus the stage latency) and maps both through the stage
// permutation. Assumes NPE = 4 lanes, eight banks, 1024 points.
module conflict_free_agen
    import agen_pkg::*;
#(
    parameter int NPE    = 4,
    parameter int CNT_W  = 8,
    parameter int GRP_W  = 5,
    parameter int BANK_W = 3,
    parameter int WORD_W = 7,
    parameter int LAT1   = 24,
    parameter int LAT2   = 24,
    parameter int LAT3   = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [1:0]              stage_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [NPE-1:0]          rd_vld_o,
    output logic [NPE*BANK_W-1:0]   rd_bank_o,
    output logic [NPE*WORD_W-1:0]   rd_word_o,
    output logic [NPE-1:0]          wr_vld_o,
    output logic [NPE*BANK_W-1:0]   wr_bank_o,
    output logic [NPE*WORD_W-1:0]   wr_word_o
);
    localparam int LANE_W  = $clog2(NPE);
    localparam int LAT_MAX = max3(LAT1, LAT2, LAT3);
    localparam int HIST_N  = LAT_MAX + 2;
    localparam int IDX_W   = $clog2(HIST_N);

    stage_e                        run_stage;
    logic                          iss_vld;
    logic [CNT_W-1:0]              iss_cnt;
    logic [HIST_N-1:0]             h_vld;
    logic [HIST_N-1:0][CNT_W-1:0]  h_cnt;
    logic [IDX_W-1:0]              lat_now;

    agen_sequencer #(
        .CNT_W(CNT_W), .GRP_W(GRP_W),
        .LAT1(LAT1), .LAT2(LAT2), .LAT3(LAT3)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .stage_i  (stage_i),
        .stage_o  (run_stage),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .iss_vld_o(iss_vld),
        .iss_cnt_o(iss_cnt)
    );

    agen_history #(.CNT_W(CNT_W), .N(HIST_N)) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (iss_vld),
        .in_cnt (iss_cnt),
        .tap_vld(h_vld),
        .tap_cnt(h_cnt)
    );

    // Read-to-write latency of the running stage.
    always_comb begin
        unique case (run_stage)
            STG_1:   lat_now = IDX_W'(LAT1);
            STG_2:   lat_now = IDX_W'(LAT2);
            default: lat_now = IDX_W'(LAT3);
        endcase
    end

    for (genvar g = 0; g < NPE; g++) begin : g_lane
        localparam logic [LANE_W-1:0] LANE_ID = LANE_W'(g);
        localparam bit                UPPER   = (g >= NPE / 2);

        logic [IDX_W-1:0]  rd_idx;
        logic [IDX_W-1:0]  wr_idx;
        logic [BANK_W-1:0] rbank;
        logic [BANK_W-1:0] wbank;
        logic [WORD_W-1:0] rword;
        logic [WORD_W-1:0] wword;

        // Tap choice: upper lanes lag one cycle in stage 3.
        always_comb begin
            rd_idx = (UPPER && (run_stage == STG_3)) ? IDX_W'(1) : '0;
            wr_idx = rd_idx + lat_now;
        end

        agen_bank_map #(
            .CNT_W(CNT_W), .LANE_W(LANE_W), .BANK_W(BANK_W), .WORD_W(WORD_W)
        ) u_rmap (
            .stage(run_stage),
            .cnt  (h_cnt[rd_idx]),
            .lane (LANE_ID),
            .bank (rbank),
            .word (rword)
        );

        agen_bank_map #(
            .CNT_W(CNT_W), .LANE_W(LANE_W), .BANK_W(BANK_W), .WORD_W(WORD_W)
        ) u_wmap (
            .stage(run_stage),
            .cnt  (h_cnt[wr_idx]),
            .lane (LANE_ID),
            .bank (wbank),
            .word (wword)
        );

        // Drive this lane's slice of the port vectors.
        always_comb begin
            rd_vld_o[g]                    = h_vld[rd_idx];
            wr_vld_o[g]                    = h_vld[wr_idx];
            rd_bank_o[g*BANK_W +: BANK_W]  = rbank;
            rd_word_o[g*WORD_W +: WORD_W]  = rword;
            wr_bank_o[g*BANK_W +: BANK_W]  = wbank;
            wr_word_o[g*WORD_W +: WORD_W]  = wword;
        end
    end

endmodule

// File: rtl/agen_checker.sv
// Module: property checker for conflict_free_agen, attached by bind below.
// Watches the ports plus the latched stage of the running pass.
module agen_checker
    import agen_pkg::*;
#(
    parameter int NPE    = 4,
    parameter int BANK_W = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start_i,
    input logic [1:0]            stage_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [NPE-1:0]        rd_vld_o,
    input logic [NPE*BANK_W-1:0] rd_bank_o,
    input logic [NPE-1:0]        wr_vld_o,
    input logic [NPE*BANK_W-1:0] wr_bank_o,
    input stage_e                run_stage
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0][2*NPE-1:0] hits;

    // Which ports touch which bank this cycle.
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            for (int p = 0; p < NPE; p++) begin
                hits[b][p]       = rd_vld_o[p] && (rd_bank_o[p*BANK_W +: BANK_W] == BANK_W'(b));
                hits[b][NPE + p] = wr_vld_o[p] && (wr_bank_o[p*BANK_W +: BANK_W] == BANK_W'(b));
            end
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        a_r8_bank_once: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hits[b]));
    end

    a_r2_launch_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(start_i) && ($past(stage_i) != 2'd3)));

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ((rd_vld_o == '0) && (wr_vld_o == '0)));

    a_r9_done_inside_pass: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    a_r9_done_ends_pass: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && !done_o));

    a_r6_upper_lags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && run_stage == STG_3 && rd_vld_o[NPE-1]) |-> $past(rd_vld_o[0]));

    a_r6_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && run_stage != STG_3) |-> (rd_vld_o[NPE-1] == rd_vld_o[0]));

endmodule

bind conflict_free_agen agen_checker #(.NPE(NPE), .BANK_W(BANK_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stage_i  (stage_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .rd_vld_o (rd_vld_o),
    .rd_bank_o(rd_bank_o),
    .wr_vld_o (wr_vld_o),
    .wr_bank_o(wr_bank_o),
    .run_stage(run_stage)
);

// File: tb/conflict_free_agen_test.sv
// Scoreboard bench: the driver queues expected (cycle, bank, word) per lane;
// the falling-edge monitor pops and compares whenever a strobe appears.
module conflict_free_agen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  stage_i = 2'd0;
    logic        busy_o, done_o;
    logic [3:0]  rd_vld_o, wr_vld_o;
    logic [11:0] rd_bank_o, wr_bank_o;
    logic [27:0] rd_word_o, wr_word_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int cur_stage = 0;
    int rdq [4][$];
    int wrq [4][$];

    conflict_free_agen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stage_i(stage_i),
        .busy_o(busy_o), .done_o(done_o),
        .rd_vld_o(rd_vld_o), .rd_bank_o(rd_bank_o), .rd_word_o(rd_word_o),
        .wr_vld_o(wr_vld_o), .wr_bank_o(wr_bank_o), .wr_word_o(wr_word_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Logical address per R3.
    function automatic int exp_addr(int s, int b, int p);
        if (s == 0) return ((b & 7) << 7) | (((b >> 3) & 31) << 2) | p;
        if (s == 1) return (((b >> 5) & 7) << 7) | ((b & 7) << 4) | (((b >> 3) & 3) << 2) | p;
        return (((b >> 5) & 7) << 7) | (((b >> 3) & 3) << 5) | (((p >> 1) & 1) << 4)
               | ((b & 7) << 1) | (p & 1);
    endfunction

    // Issue cycle offset per R4 and R5.
    function automatic int issue_off(int s, int i);
        if (s == 0) return i;
        return (i >> 5) * (32 + ((s == 1) ? 24 : 23)) + (i & 31);
    endfunction

    function automatic string tag_rd(int s);
        if (s == 0) return "R4";
        if (s == 1) return "R5";
        return "R6";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Monitor: compare every strobe with the head of its lane queue.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < 4; p++) begin
                if (rd_vld_o[p]) begin
                    if (rdq[p].size() == 0) begin
                        check(1'b0, tag_rd(cur_stage), "unexpected read strobe", p, -1);
                    end else begin
                        int it;
                        it = rdq[p].pop_front();
                        check(cyc == (it >> 16), tag_rd(cur_stage), "read cycle", cyc, it >> 16);
                        check({rd_bank_o[p*3 +: 3], rd_word_o[p*7 +: 7]} == 10'((it >> 8 & 7) << 7 | (it & 127)),
                              "R3", "read bank/word", {rd_bank_o[p*3 +: 3], rd_word_o[p*7 +: 7]},
                              ((it >> 8 & 7) << 7) | (it & 127));
                    end
                end
                if (wr_vld_o[p]) begin
                    if (wrq[p].size() == 0) begin
                        check(1'b0, "R7", "unexpected write strobe", p, -1);
                    end else begin
                        int it;
                        it = wrq[p].pop_front();
                        check(cyc == (it >> 16), "R7", "write cycle", cyc, it >> 16);
                        check({wr_bank_o[p*3 +: 3], wr_word_o[p*7 +: 7]} == 10'((it >> 8 & 7) << 7 | (it & 127)),
                              "R7", "write bank/word", {wr_bank_o[p*3 +: 3], wr_word_o[p*7 +: 7]},
                              ((it >> 8 & 7) << 7) | (it & 127));
                    end
                end
            end
            if ((rd_vld_o | wr_vld_o) != 4'd0) begin
                int worst;
                worst = 0;
                for (int b = 0; b < 8; b++) begin
                    int n;
                    n = 0;
                    for (int p = 0; p < 4; p++) begin
                        if (rd_vld_o[p] && rd_bank_o[p*3 +: 3] == 3'(b)) n++;
                        if (wr_vld_o[p] && wr_bank_o[p*3 +: 3] == 3'(b)) n++;
                    end
                    if (n > worst) worst = n;
                end
                check(worst <= 1, "R8", "accesses to one bank", worst, 1);
            end
        end
    end

    // Driver: queue the expectations of one pass, launch it, await done.
    task automatic run_stage(input int s, input bit poke);
        int base, lat, last, dend, seen;
        @(negedge clk);
        cur_stage = s;
        base = cyc + 1;
        lat  = (s == 2) ? 22 : 24;
        for (int i = 0; i < 256; i++) begin
            for (int p = 0; p < 4; p++) begin
                int a, t, item;
                a = exp_addr(s, i, p);
                t = base + issue_off(s, i) + ((s == 2 && p >= 2) ? 1 : 0);
                item = ((((a >> 7) + (a & 7)) & 7) << 8) | (a & 127);
                rdq[p].push_back((t << 16) | item);
                wrq[p].push_back(((t + lat) << 16) | item);
            end
        end
        last = base + issue_off(s, 255);
        dend = last + ((s == 2) ? 23 : 24);
        stage_i = 2'(s);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        if (poke) begin
            repeat (100) @(negedge clk);
            stage_i = 2'd0;
            start_i = 1'b1;   // R10: must be ignored mid-pass
            @(negedge clk);
            start_i = 1'b0;
        end
        seen = 0;
        while (!done_o && seen < 2000) begin
            @(negedge clk);
            seen++;
        end
        check(cyc == dend, "R9", "done cycle", cyc, dend);
        @(negedge clk);
        check(done_o == 1'b0, "R9", "done width", done_o, 0);
        check(busy_o == 1'b0, "R9", "busy after done", busy_o, 0);
        for (int p = 0; p < 4; p++) begin
            check(rdq[p].size() == 0, poke ? "R10" : tag_rd(s), "reads left", rdq[p].size(), 0);
            check(wrq[p].size() == 0, "R7", "writes left", wrq[p].size(), 0);
        end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy_o == 1'b0, "R1", "busy", busy_o, 0);
        check(done_o == 1'b0, "R1", "done", done_o, 0);
        check(rd_vld_o == 4'd0, "R1", "read strobes", rd_vld_o, 0);
        check(wr_vld_o == 4'd0, "R1", "write strobes", wr_vld_o, 0);

        // R2: stage code 3 is rejected
        stage_i = 2'd3;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check(busy_o == 1'b0, "R2", "busy after bad stage", busy_o, 0);
            check((rd_vld_o | wr_vld_o) == 4'd0, "R2", "strobes after bad stage",
                  rd_vld_o | wr_vld_o, 0);
            @(negedge clk);
        end

        run_stage(0, 1'b0);
        run_stage(1, 1'b0);
        run_stage(2, 1'b0);
        run_stage(1, 1'b1);
        run_stage(2, 1'b1);
        finish_up();
    end

endmodule